// File: doc/BRIEF.md
# Loopback Packet DMA Flow Router

This block models the internal loopback path of a packet DMA engine that moves data between queues without any external peripheral. It has 32 transmit channels, each fed by its own queue. When a queue signals that work is pending, the block arbitrates among the pending channels. It takes the winning channel's descriptor fields and reads that channel's payload words in order through a buffer read port. Each word is streamed straight back into the receive side on the receive channel with the same number.

The receive side does not forward the transmit descriptor. It builds a new one. The transmit descriptor may carry a flow tag. When the tag is marked valid and names one of the 32 flows, that flow is used. Otherwise the flow equal to the channel number is used. Each flow holds a destination queue number, which software programs through a one-word register write port. At the last payload word the block raises one push pulse carrying three fields: the destination queue, the length moved and the flow index used. In the same cycle it acknowledges the source channel so the queue can retire its entry.

Top module: `lbdma_router`

## Requirements
- R1: After reset no payload word, push or acknowledge is issued, and every flow's destination queue number is 0.
- R2: When several channels are pending together, the lowest-numbered pending channel is served first.
- R3: A granted transfer runs to its last word before any new arbitration. A lower channel that becomes pending mid-transfer waits. The cycle after an acknowledge carries no payload word.
- R4: The payload of channel N is read at indices 0 to length-1 in order, one word per cycle with no gaps. Each word appears on the receive write port tagged with receive channel N, one register stage after it is read.
- R5: When the tag-valid bit is set and the 8-bit tag is below 32, the receive flow is the tag value.
- R6: When the tag-valid bit is clear, the receive flow is the channel number.
- R7: When the tag-valid bit is set but the tag is 32 or above, the tag is ignored and the receive flow is the channel number.
- R8: The push pulse lasts one cycle per packet, in the same cycle as the last payload word. It carries the destination queue number stored in the chosen flow, the number of words moved and the flow index.
- R9: A register write stores the destination queue number of the addressed flow only. All other flows keep their values.
- R10: Each packet produces exactly one acknowledge, one-hot on the source channel's bit, in the same cycle as its push.
- R11: A descriptor length of 0 is moved as a single word and pushed with length 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_pend | input | 32 | Per-channel queue-pending flags |
| tx_len | input | 32x8 | Per-channel payload length in words |
| tx_tag | input | 32x8 | Per-channel flow tag |
| tx_tag_vld | input | 32 | Per-channel flow-tag valid bit |
| tx_rd_en | output | 1 | Payload read active |
| tx_rd_ch | output | 5 | Channel whose payload is read |
| tx_rd_idx | output | 8 | Word index being read |
| tx_rd_data | input | 32 | Payload word at the read address (same cycle) |
| tx_ack | output | 32 | One-hot end-of-packet acknowledge |
| cfg_we | input | 1 | Flow register write strobe |
| cfg_flow | input | 5 | Flow index written |
| cfg_qnum | input | 12 | Destination queue number written |
| rx_wr_vld | output | 1 | Looped-back payload word valid |
| rx_wr_ch | output | 5 | Receive channel of the word |
| rx_wr_data | output | 32 | Looped-back payload word |
| out_vld | output | 1 | Output descriptor push |
| out_qnum | output | 12 | Destination queue of the push |
| out_len | output | 8 | Words moved |
| out_flow | output | 5 | Flow index used |

## Verification
Each payload word encodes its channel and index, so a word that is misrouted, reordered or dropped shows up as a data mismatch. Single packets are sent with the tag clear, with the tag valid and in range, and with the tag valid but out of range. These separate tag-driven flow selection from the channel fallback. Simultaneous requests on three channels expose the arbitration order. A low channel raised while a higher one is mid-transfer separates run-to-completion from preemption. Writes to neighbouring flows, plus a packet through a never-written flow, show that a write touches only its own register. A zero-length descriptor covers the single-word edge case.

// File: rtl/lbdma_pkg.sv
package lbdma_pkg;
    localparam int NCH    = 32;
    localparam int CH_W   = $clog2(NCH);
    localparam int TAG_W  = 8;
    localparam int LEN_W  = 8;
    localparam int QNUM_W = 12;
    localparam int DATA_W = 32;

    typedef logic [CH_W-1:0]   ch_t;
    typedef logic [LEN_W-1:0]  len_t;
    typedef logic [QNUM_W-1:0] qnum_t;
    typedef logic [DATA_W-1:0] word_t;

    // one looped-back stream beat
    typedef struct packed {
        logic  vld;
        logic  last;
        ch_t   ch;
        ch_t   flow;
        len_t  len;
        word_t data;
    } beat_t;

    // flow chosen for a packet: valid in-range tag, else the channel itself
    function automatic ch_t pick_flow(ch_t ch, logic tag_vld, logic [TAG_W-1:0] tag);
        if (tag_vld && (tag < TAG_W'(NCH)))
            return tag[CH_W-1:0];
        return ch;
    endfunction

    // a zero length still moves one word
    function automatic len_t eff_len(len_t l);
        return (l == '0) ? len_t'(1) : l;
    endfunction
endpackage

// File: rtl/lbdma_arb.sv
module lbdma_arb
    import lbdma_pkg::*;
(
    input  logic [NCH-1:0] req,
    output logic           gnt_vld,
    output ch_t            gnt_ch
);
    always_comb begin
        gnt_vld = 1'b0;
        gnt_ch  = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt_vld = 1'b1;
                gnt_ch  = ch_t'(i);
            end
        end
    end
endmodule

// File: rtl/lbdma_tx.sv
module lbdma_tx
    import lbdma_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       gnt_vld,
    input  ch_t                        gnt_ch,
    input  logic [NCH-1:0][LEN_W-1:0]  tx_len,
    input  logic [NCH-1:0][TAG_W-1:0]  tx_tag,
    input  logic [NCH-1:0]             tx_tag_vld,
    output logic                       busy,
    output ch_t                        rd_ch,
    output len_t                       rd_idx,
    input  word_t                      rd_data,
    output beat_t                      beat,
    output logic [NCH-1:0]             ack
);
    ch_t  cur_ch;
    ch_t  cur_flow;
    len_t cur_len;
    len_t cnt;
    logic is_last;

    assign is_last = (cnt == cur_len - len_t'(1));
    assign rd_ch   = cur_ch;
    assign rd_idx  = cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            cur_ch   <= '0;
            cur_flow <= '0;
            cur_len  <= '0;
            cnt      <= '0;
            beat     <= '0;
            ack      <= '0;
        end else begin
            ack      <= '0;
            beat.vld <= 1'b0;
            if (!busy) begin
                if (gnt_vld) begin
                    busy     <= 1'b1;
                    cur_ch   <= gnt_ch;
                    cur_len  <= eff_len(tx_len[gnt_ch]);
                    cur_flow <= pick_flow(gnt_ch, tx_tag_vld[gnt_ch], tx_tag[gnt_ch]);
                    cnt      <= '0;
                end
            end else begin
                beat.vld  <= 1'b1;
                beat.last <= is_last;
                beat.ch   <= cur_ch;
                beat.flow <= cur_flow;
                beat.len  <= cur_len;
                beat.data <= rd_data;
                cnt       <= cnt + len_t'(1);
                if (is_last) begin
                    busy <= 1'b0;
                    ack  <= NCH'(1) << cur_ch;
                end
            end
        end
    end
endmodule

// File: rtl/lbdma_flow_tbl.sv
module lbdma_flow_tbl
    import lbdma_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  ch_t   waddr,
    input  qnum_t wdata,
    input  ch_t   raddr,
    output qnum_t rdata
);
    qnum_t dest_q [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_flow
        always_ff @(posedge clk) begin
            if (rst)
                dest_q[g] <= '0;
            else if (we && (waddr == ch_t'(g)))
                dest_q[g] <= wdata;
        end
    end

    assign rdata = dest_q[raddr];
endmodule

// File: rtl/lbdma_router.sv
module lbdma_router
    import lbdma_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NCH-1:0]             tx_pend,
    input  logic [NCH-1:0][LEN_W-1:0]  tx_len,
    input  logic [NCH-1:0][TAG_W-1:0]  tx_tag,
    input  logic [NCH-1:0]             tx_tag_vld,
    output logic                       tx_rd_en,
    output logic [CH_W-1:0]            tx_rd_ch,
    output logic [LEN_W-1:0]           tx_rd_idx,
    input  logic [DATA_W-1:0]          tx_rd_data,
    output logic [NCH-1:0]             tx_ack,
    input  logic                       cfg_we,
    input  logic [CH_W-1:0]            cfg_flow,
    input  logic [QNUM_W-1:0]          cfg_qnum,
    output logic                       rx_wr_vld,
    output logic [CH_W-1:0]            rx_wr_ch,
    output logic [DATA_W-1:0]          rx_wr_data,
    output logic                       out_vld,
    output logic [QNUM_W-1:0]          out_qnum,
    output logic [LEN_W-1:0]           out_len,
    output logic [CH_W-1:0]            out_flow
);
    logic  gnt_vld;
    ch_t   gnt_ch;
    logic  busy;
    beat_t beat;
    qnum_t flow_q;

    lbdma_arb u_arb (
        .req     (tx_pend),
        .gnt_vld (gnt_vld),
        .gnt_ch  (gnt_ch)
    );

    lbdma_tx u_tx (
        .clk        (clk),
        .rst        (rst),
        .gnt_vld    (gnt_vld),
        .gnt_ch     (gnt_ch),
        .tx_len     (tx_len),
        .tx_tag     (tx_tag),
        .tx_tag_vld (tx_tag_vld),
        .busy       (busy),
        .rd_ch      (tx_rd_ch),
        .rd_idx     (tx_rd_idx),
        .rd_data    (tx_rd_data),
        .beat       (beat),
        .ack        (tx_ack)
    );

    lbdma_flow_tbl u_flow (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .waddr (cfg_flow),
        .wdata (cfg_qnum),
        .raddr (beat.flow),
        .rdata (flow_q)
    );

    assign tx_rd_en   = busy;
    assign rx_wr_vld  = beat.vld;
    assign rx_wr_ch   = beat.ch;
    assign rx_wr_data = beat.data;
    assign out_vld    = beat.vld && beat.last;
    assign out_qnum   = flow_q;
    assign out_len    = beat.len;
    assign out_flow   = beat.flow;
endmodule

module lbdma_router_chk
    import lbdma_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic [NCH-1:0] tx_ack,
    input logic           out_vld,
    input logic           rx_wr_vld,
    input logic [CH_W-1:0] rx_wr_ch
);
    // R10
    ack_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(tx_ack));

    // R10
    ack_with_push_chk: assert property (@(posedge clk) disable iff (rst)
        (out_vld || (tx_ack != '0)) |-> (out_vld && (tx_ack != '0)));

    // R8
    push_on_word_chk: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> rx_wr_vld);

    // R4
    beat_contig_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_wr_vld && !out_vld) |=> (rx_wr_vld && $stable(rx_wr_ch)));

    // R3
    gap_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_ack != '0) |=> !rx_wr_vld);
endmodule

bind lbdma_router lbdma_router_chk u_lbdma_router_chk (
    .clk       (clk),
    .rst       (rst),
    .tx_ack    (tx_ack),
    .out_vld   (out_vld),
    .rx_wr_vld (rx_wr_vld),
    .rx_wr_ch  (rx_wr_ch)
);

// File: tb/lbdma_router_bench.sv
module lbdma_router_bench;
    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [31:0]       tx_pend = '0;
    logic [31:0][7:0]  tx_len = '0;
    logic [31:0][7:0]  tx_tag = '0;
    logic [31:0]       tx_tag_vld = '0;
    logic              tx_rd_en;
    logic [4:0]        tx_rd_ch;
    logic [7:0]        tx_rd_idx;
    logic [31:0]       tx_rd_data;
    logic [31:0]       tx_ack;
    logic              cfg_we = 1'b0;
    logic [4:0]        cfg_flow = '0;
    logic [11:0]       cfg_qnum = '0;
    logic              rx_wr_vld;
    logic [4:0]        rx_wr_ch;
    logic [31:0]       rx_wr_data;
    logic              out_vld;
    logic [11:0]       out_qnum;
    logic [7:0]        out_len;
    logic [4:0]        out_flow;

    int errors = 0;
    int checks = 0;
    int log_ch   [0:7];
    int log_q    [0:7];
    int log_len  [0:7];
    int log_flow [0:7];

    always #10 clk = ~clk;

    function automatic logic [31:0] word_of(input logic [4:0] ch, input logic [7:0] idx);
        return {8'hC0, 3'b000, ch, idx, idx ^ 8'h5A};
    endfunction

    assign tx_rd_data = word_of(tx_rd_ch, tx_rd_idx);

    lbdma_router u_lbdma_router (
        .clk(clk), .rst(rst), .tx_pend(tx_pend), .tx_len(tx_len), .tx_tag(tx_tag),
        .tx_tag_vld(tx_tag_vld), .tx_rd_en(tx_rd_en), .tx_rd_ch(tx_rd_ch),
        .tx_rd_idx(tx_rd_idx), .tx_rd_data(tx_rd_data), .tx_ack(tx_ack),
        .cfg_we(cfg_we), .cfg_flow(cfg_flow), .cfg_qnum(cfg_qnum),
        .rx_wr_vld(rx_wr_vld), .rx_wr_ch(rx_wr_ch), .rx_wr_data(rx_wr_data),
        .out_vld(out_vld), .out_qnum(out_qnum), .out_len(out_len), .out_flow(out_flow)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(input int flow, input int q);
        @(negedge clk);
        cfg_we = 1'b1; cfg_flow = 5'(flow); cfg_qnum = 12'(q);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_desc(input int ch, input int len, input bit tv, input int tag);
        tx_len[ch] = 8'(len); tx_tag_vld[ch] = tv; tx_tag[ch] = 8'(tag);
    endtask

    // collects n pushes, checking every word and retiring acked channels
    task automatic wait_pkts(input int n);
        int got = 0;
        int idx = 0;
        int guard = 0;
        while (got < n && guard < 3000) begin
            @(negedge clk);
            guard++;
            if (rx_wr_vld) begin
                chk(rx_wr_data == word_of(rx_wr_ch, 8'(idx)), "R4 word", rx_wr_data,
                    word_of(rx_wr_ch, 8'(idx)));
                idx++;
            end
            if (out_vld) begin
                chk(tx_ack == (32'd1 << rx_wr_ch), "R10 ack", tx_ack, 32'd1 << rx_wr_ch);
                chk(int'(out_len) == idx, "R8 words moved", idx, out_len);
                log_ch[got] = rx_wr_ch; log_q[got] = out_qnum;
                log_len[got] = out_len; log_flow[got] = out_flow;
                tx_pend = tx_pend & ~tx_ack;
                idx = 0;
                got++;
            end
        end
        chk(got == n, "R8 push count", got, n);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!out_vld && !rx_wr_vld && tx_ack == '0, "R1 idle outputs", out_vld, 0);
        set_desc(1, 3, 1'b0, 0);
        tx_pend[1] = 1'b1;
        wait_pkts(1);
        chk(log_q[0] == 0, "R1 flow reset qnum", log_q[0], 0);
    endtask

    task automatic t_default_flow();
        cfg_write(7, 100);
        set_desc(7, 4, 1'b0, 2);
        tx_pend[7] = 1'b1;
        wait_pkts(1);
        chk(log_flow[0] == 7, "R6 fallback flow", log_flow[0], 7);
        chk(log_q[0] == 100, "R8 dest qnum", log_q[0], 100);
        chk(log_len[0] == 4, "R8 length", log_len[0], 4);
        chk(log_ch[0] == 7, "R4 rx channel", log_ch[0], 7);
    endtask

    task automatic t_tag_flow();
        cfg_write(12, 55);
        set_desc(3, 5, 1'b1, 12);
        tx_pend[3] = 1'b1;
        wait_pkts(1);
        chk(log_flow[0] == 12, "R5 tag flow", log_flow[0], 12);
        chk(log_q[0] == 55, "R5 tag qnum", log_q[0], 55);
    endtask

    task automatic t_tag_range();
        cfg_write(9, 77);
        set_desc(9, 2, 1'b1, 40);
        tx_pend[9] = 1'b1;
        wait_pkts(1);
        chk(log_flow[0] == 9, "R7 out-of-range tag", log_flow[0], 9);
        chk(log_q[0] == 77, "R7 fallback qnum", log_q[0], 77);
    endtask

    task automatic t_priority();
        @(negedge clk);
        set_desc(20, 2, 1'b0, 0);
        set_desc(5, 3, 1'b0, 0);
        set_desc(3, 2, 1'b0, 0);
        tx_pend[20] = 1'b1; tx_pend[5] = 1'b1; tx_pend[3] = 1'b1;
        wait_pkts(3);
        chk(log_ch[0] == 3, "R2 first", log_ch[0], 3);
        chk(log_ch[1] == 5, "R2 second", log_ch[1], 5);
        chk(log_ch[2] == 20, "R2 third", log_ch[2], 20);
    endtask

    task automatic t_no_preempt();
        @(negedge clk);
        set_desc(10, 6, 1'b0, 0);
        set_desc(2, 2, 1'b0, 0);
        tx_pend[10] = 1'b1;
        @(negedge clk);
        tx_pend[2] = 1'b1;
        wait_pkts(2);
        chk(log_ch[0] == 10, "R3 running first", log_ch[0], 10);
        chk(log_len[0] == 6, "R3 full length", log_len[0], 6);
        chk(log_ch[1] == 2, "R3 waiter second", log_ch[1], 2);
    endtask

    task automatic t_cfg_isolate();
        cfg_write(4, 200);
        cfg_write(5, 201);
        set_desc(4, 1, 1'b0, 0);
        tx_pend[4] = 1'b1;
        wait_pkts(1);
        chk(log_q[0] == 200, "R9 neighbour write", log_q[0], 200);
        set_desc(5, 1, 1'b0, 0);
        tx_pend[5] = 1'b1;
        wait_pkts(1);
        chk(log_q[0] == 201, "R9 own write", log_q[0], 201);
    endtask

    task automatic t_len_zero();
        cfg_write(0, 9);
        set_desc(0, 0, 1'b0, 0);
        tx_pend[0] = 1'b1;
        wait_pkts(1);
        chk(log_len[0] == 1, "R11 zero length", log_len[0], 1);
        chk(log_q[0] == 9, "R11 qnum", log_q[0], 9);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_default_flow();
        t_tag_flow();
        t_tag_range();
        t_priority();
        t_no_preempt();
        t_cfg_isolate();
        t_len_zero();
        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
        $finish;
    end
endmodule